// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits at the front of a simple processor pipeline. Each cycle it takes the current fetch address, presents it to an instruction memory that returns the six bytes starting at that address with one error flag per byte, and splits the instruction found there into its fields. The first byte gives an operation code and a function code. Depending on the operation code, a register-specifier byte and a four-byte immediate may follow, so an instruction is 1, 2, 5 or 6 bytes long.

All decoded fields are registered once and presented on the next clock edge. The outputs are:

- the operation and function codes;
- the two register specifiers;
- the immediate;
- the address of the following instruction, called the fall-through address;
- a predicted next fetch address;
- a fetch status.

When the instruction cannot be fetched cleanly, or halts, a flag marks the next fetch slot as a bubble. If the first byte cannot be read, the instruction is replaced by a no-op.

Top module: `fetch_decoder`

## Requirements
- R1: While `rst_n` is low, the registered outputs take these values: operation code 1, function code 0, both specifiers 0xF, immediate 0, fall-through 0, prediction 0, status OK, bubble flag 0. The status encoding is OK=0, HALT=1, ADDR (address fault)=2, INSTR (illegal instruction)=3.
- R2: Byte k at the fetch address is `mem_data[8k+7:8k]`. For an instruction whose first byte reads cleanly, the operation code is bits 7:4 of byte 0 and the function code is bits 3:0 of byte 0.
- R3: Operation codes 2, 3, 4, 5, 6, 0xA and 0xB carry a register byte at offset 1. Its upper nibble is the first specifier and its lower nibble is the second. For all other codes, both specifiers read 0xF.
- R4: Operation codes 3, 4, 5, 7 and 8 carry a four-byte little-endian immediate. It follows the register byte when one is present and otherwise starts at offset 1. For all other codes, the immediate reads 0.
- R5: The fall-through address is the fetch address plus 1, plus 1 more when a register byte is present, plus 4 more when an immediate is present. It wraps modulo 2^AW.
- R6: If `mem_err[0]` is set, the result is operation code 1, function code 0, status ADDR, specifiers 0xF, immediate 0 and fall-through equal to the fetch address plus 1.
- R7: A cleanly read operation code of 0xC or above gives status INSTR with no register byte and no immediate. Operation code 0 gives status HALT. Any other clean instruction gives status OK.
- R8: A fault flag on a register byte that is actually needed gives status ADDR and forces both specifiers to 0xF. A fault flag on any needed immediate byte gives status ADDR and forces the immediate to 0. Flags on bytes the instruction does not use have no effect.
- R9: When a register byte is read cleanly and either nibble is in 8..14, the status is INSTR, unless an immediate fault has already made it ADDR. The value 0xF means "no register" and is legal.
- R10: The bubble flag is 1 exactly when the registered status is not OK.
- R11: The prediction equals the immediate for operation codes 7 and 8 when the immediate reads cleanly. Otherwise it equals the fall-through address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_in | input | AW | Fetch address for this cycle |
| mem_addr | output | AW | Address presented to instruction memory |
| mem_data | input | 48 | Six bytes read from `mem_addr` upward, byte 0 in the low bits |
| mem_err | input | 6 | Per-byte invalid-address flags, bit k for byte k |
| d_op | output | 4 | Registered operation code |
| d_fn | output | 4 | Registered function code |
| d_ra | output | 4 | Registered first register specifier |
| d_rb | output | 4 | Registered second register specifier |
| d_imm | output | 32 | Registered immediate |
| d_fall | output | AW | Registered fall-through address |
| d_pred | output | AW | Registered predicted next fetch address |
| d_stat | output | 2 | Registered fetch status |
| pc_bubble | output | 1 | Next fetch slot is a bubble |

## Verification
The assertions assume two things. First, the memory answers within the same cycle, so `mem_data` and `mem_err` are settled before each rising edge. Second, the error flags describe the six bytes that follow the address on `mem_addr`. The bench meets both by changing every input at the falling edge and computing each error vector together with its fetch address. Random stimulus mixes all sixteen operation codes, mostly-legal register nibbles and occasional fault patterns, and directed cases cover wrap-around addresses, fault flags on unused bytes and the ADDR-over-INSTR precedence.

// File: rtl/fetch_decoder.sv
module fetch_decoder #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_in,
  output logic [AW-1:0] mem_addr,
  input  logic [47:0]   mem_data,
  input  logic [5:0]    mem_err,
  output logic [3:0]    d_op,
  output logic [3:0]    d_fn,
  output logic [3:0]    d_ra,
  output logic [3:0]    d_rb,
  output logic [31:0]   d_imm,
  output logic [AW-1:0] d_fall,
  output logic [AW-1:0] d_pred,
  output logic [1:0]    d_stat,
  output logic          pc_bubble
);
  localparam logic [1:0] ST_OK = 2'd0, ST_HALT = 2'd1, ST_ADDR = 2'd2, ST_INSTR = 2'd3;
  localparam logic [3:0] NOREG = 4'hF;

  logic        lead_bad, need_reg, need_imm, reg_bad, imm_bad, spec_bad, known;
  logic [3:0]  op, fn, ra, rb;
  logic [31:0] imm_raw, imm;
  logic [AW-1:0] fall, pred;
  logic [1:0]  stat;

  assign mem_addr = pc_in;
  assign lead_bad = mem_err[0];
  assign op = lead_bad ? 4'h1 : mem_data[7:4];
  assign fn = lead_bad ? 4'h0 : mem_data[3:0];
  assign known = (op <= 4'hB);

  always_comb begin
    case (op)
      4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB: need_reg = 1'b1;
      default:                                  need_reg = 1'b0;
    endcase
    case (op)
      4'h3, 4'h4, 4'h5, 4'h7, 4'h8: need_imm = 1'b1;
      default:                      need_imm = 1'b0;
    endcase
  end

  assign reg_bad = need_reg & mem_err[1];
  assign imm_bad = need_imm & (need_reg ? |mem_err[5:2] : |mem_err[4:1]);
  assign imm_raw = need_reg ? mem_data[47:16] : mem_data[39:8];
  assign ra = (need_reg && !reg_bad) ? mem_data[15:12] : NOREG;
  assign rb = (need_reg && !reg_bad) ? mem_data[11:8]  : NOREG;
  assign spec_bad = (ra[3] && ra != NOREG) || (rb[3] && rb != NOREG);
  assign imm = (need_imm && !imm_bad) ? imm_raw : 32'd0;
  assign fall = pc_in + AW'(1) + AW'(need_reg) + (need_imm ? AW'(4) : AW'(0));
  assign pred = ((op == 4'h7 || op == 4'h8) && !imm_bad) ? AW'(imm) : fall;

  always_comb begin
    if (lead_bad)                stat = ST_ADDR;
    else if (!known)             stat = ST_INSTR;
    else if (reg_bad || imm_bad) stat = ST_ADDR;
    else if (spec_bad)           stat = ST_INSTR;
    else if (op == 4'h0)         stat = ST_HALT;
    else                         stat = ST_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_op <= 4'h1; d_fn <= 4'h0; d_ra <= NOREG; d_rb <= NOREG;
      d_imm <= '0; d_fall <= '0; d_pred <= '0; d_stat <= ST_OK; pc_bubble <= 1'b0;
    end else begin
      d_op <= op; d_fn <= fn; d_ra <= ra; d_rb <= rb;
      d_imm <= imm; d_fall <= fall; d_pred <= pred; d_stat <= stat;
      pc_bubble <= (stat != ST_OK);
    end
  end

  p_lead_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_err[0] |=> (d_op == 4'h1 && d_fn == 4'h0 && d_stat == ST_ADDR && d_fall == $past(pc_in) + AW'(1)));

  p_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (d_fall - $past(pc_in) == AW'(1) || d_fall - $past(pc_in) == AW'(2) ||
              d_fall - $past(pc_in) == AW'(5) || d_fall - $past(pc_in) == AW'(6)));

  p_no_regbyte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !need_reg |=> (d_ra == NOREG && d_rb == NOREG));

  p_no_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !need_imm |=> (d_imm == 32'd0));

  p_pred_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (d_op != 4'h7 && d_op != 4'h8) |-> (d_pred == d_fall));

  p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_bubble == (d_stat != ST_OK));
endmodule

// File: tb/tb_fetch_decoder.sv
`timescale 1ns/1ps
module tb_fetch_decoder;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] pc_in = '0, mem_addr;
  logic [47:0] mem_data = '0;
  logic [5:0]  mem_err = '0;
  logic [3:0]  d_op, d_fn, d_ra, d_rb;
  logic [31:0] d_imm;
  logic [AW-1:0] d_fall, d_pred;
  logic [1:0]  d_stat;
  logic        pc_bubble;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_decoder #(.AW(AW)) dut (.clk(clk), .rst_n(rst_n), .pc_in(pc_in), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_err(mem_err), .d_op(d_op), .d_fn(d_fn), .d_ra(d_ra), .d_rb(d_rb),
    .d_imm(d_imm), .d_fall(d_fall), .d_pred(d_pred), .d_stat(d_stat), .pc_bubble(pc_bubble));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic has_reg(input logic [3:0] o);
    return (o >= 4'h2 && o <= 4'h6) || o == 4'hA || o == 4'hB;
  endfunction
  function automatic logic has_imm(input logic [3:0] o);
    return (o >= 4'h3 && o <= 4'h5) || o == 4'h7 || o == 4'h8;
  endfunction
  function automatic logic bad_spec(input logic [3:0] s);
    return s >= 4'h8 && s <= 4'hE;
  endfunction

  task automatic apply(input logic [AW-1:0] pc, input logic [47:0] data, input logic [5:0] err);
    logic [3:0] eop, efn, era, erb;
    logic [31:0] eimm;
    logic [AW-1:0] efall, epred;
    logic [1:0] est;
    logic rb_ok, ib_ok;
    int ioff;
    @(negedge clk);
    pc_in = pc; mem_data = data; mem_err = err;
    eop = err[0] ? 4'h1 : data[7:4];
    efn = err[0] ? 4'h0 : data[3:0];
    era = 4'hF; erb = 4'hF; eimm = 0; est = 2'd0;
    efall = pc + 1;
    rb_ok = 1; ib_ok = 1;
    if (has_reg(eop)) begin
      efall = efall + 1;
      rb_ok = !err[1];
      if (rb_ok) begin era = data[15:12]; erb = data[11:8]; end
    end
    if (has_imm(eop)) begin
      ioff = has_reg(eop) ? 2 : 1;
      for (int k = 0; k < 4; k++) begin
        if (err[ioff+k]) ib_ok = 0;
        eimm[8*k +: 8] = data[8*(ioff+k) +: 8];
      end
      if (!ib_ok) eimm = 0;
      efall = efall + 4;
    end
    if (err[0]) est = 2'd2;
    else if (eop >= 4'hC) est = 2'd3;
    else if (!rb_ok || !ib_ok) est = 2'd2;
    else if (bad_spec(era) || bad_spec(erb)) est = 2'd3;
    else if (eop == 4'h0) est = 2'd1;
    epred = ((eop == 4'h7 || eop == 4'h8) && ib_ok) ? eimm : efall;
    @(posedge clk); #1;
    chk("R2 op", d_op, eop);
    chk("R2 fn", d_fn, efn);
    chk("R3 ra", d_ra, era);
    chk("R3 rb", d_rb, erb);
    chk("R4 imm", d_imm, eimm);
    chk("R5 fall", d_fall, efall);
    chk("R7 stat", d_stat, est);
    chk("R10 bubble", pc_bubble, est != 2'd0);
    chk("R11 pred", d_pred, epred);
  endtask

  function automatic logic [47:0] pk(input logic [7:0] b0, input logic [7:0] b1, input logic [31:0] w);
    return {w, b1, b0};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 op", d_op, 4'h1);   chk("R1 fn", d_fn, 4'h0);
    chk("R1 ra", d_ra, 4'hF);   chk("R1 rb", d_rb, 4'hF);
    chk("R1 imm", d_imm, 0);    chk("R1 fall", d_fall, 0);
    chk("R1 pred", d_pred, 0);  chk("R1 stat", d_stat, 0);
    chk("R1 bubble", pc_bubble, 0);
    @(negedge clk); rst_n = 1'b1;

    apply(32'h100, pk(8'h00, 8'h12, 32'h0), 6'b000000);             // R7 halt
    apply(32'h200, pk(8'h30, 8'hF3, 32'h12345678), 6'b000000);      // R4 little-endian, 6 bytes
    apply(32'h300, pk(8'h73, 8'h78, 32'hAABBCCDD), 6'b100000);      // R11 jump, unused byte 5 fault ignored (R8)
    apply(32'h310, pk(8'h80, 8'h00, 32'h00004000), 6'b000000);      // R11 call
    apply(32'h320, pk(8'h90, 8'h55, 32'h0), 6'b111110);             // R8 unused faults ignored
    apply(32'h330, pk(8'hA0, 8'h4F, 32'h0), 6'b000000);             // R3 push
    apply(32'h340, pk(8'h60, 8'h12, 32'h0), 6'b000000);             // R3 alu
    apply(32'h400, pk(8'h60, 8'h12, 32'h0), 6'b000001);             // R6 lead fault
    apply(32'h410, pk(8'h30, 8'hF1, 32'h11223344), 6'b100000);      // R8 imm fault
    apply(32'h420, pk(8'h70, 8'h00, 32'h99999999), 6'b010000);      // R8 jump imm fault, R11 fallback
    apply(32'h430, pk(8'h60, 8'h12, 32'h0), 6'b000010);             // R8 reg byte fault
    apply(32'h440, pk(8'h20, 8'h8F, 32'h0), 6'b000000);             // R9 bad rA
    apply(32'h450, pk(8'h20, 8'h0E, 32'h0), 6'b000000);             // R9 bad rB
    apply(32'h460, pk(8'h40, 8'h9F, 32'h0), 6'b001000);             // R9 ADDR wins over bad spec
    apply(32'h470, pk(8'hC0, 8'h00, 32'h0), 6'b000000);             // R7 illegal
    apply(32'h480, pk(8'hF5, 8'h00, 32'h0), 6'b000000);             // R7 illegal
    apply(32'hFFFF_FFFC, pk(8'h50, 8'h31, 32'h0), 6'b000000);       // R5 wrap

    for (int i = 0; i < 600; i++) begin
      logic [7:0] b0, b1;
      logic [3:0] hi, lo;
      logic [5:0] e;
      b0 = 8'($urandom);
      hi = ($urandom % 4 == 0) ? 4'hF : (($urandom % 6 == 0) ? 4'($urandom) : 4'($urandom % 8));
      lo = ($urandom % 4 == 0) ? 4'hF : (($urandom % 6 == 0) ? 4'($urandom) : 4'($urandom % 8));
      b1 = {hi, lo};
      e = ($urandom % 6 == 0) ? 6'($urandom) : 6'd0;
      apply($urandom, pk(b0, b1, $urandom), e);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule